// File: doc/BRIEF.md
# Crosswise 24x24 Unsigned Multiplier

This block multiplies two unsigned 24-bit operands and returns the full 48-bit product with no clock. The product is built from a hierarchy of explicit gates rather than a multiply operator. At the bottom is a 4x4 cell that takes AND partial products and sums them one column at a time with half and full adders, which is the vertical-and-crosswise method. Each column sum is its cross terms plus the carries from the column below. The low bit of that sum is the result bit, and the higher bits move up to the next column. The lowest column has no incoming carry.

An 8x8 stage splits both operands into high and low nibbles. It forms the four nibble products with 4x4 cells and merges them with three 8-bit ripple-carry adders. The top splits each operand into three byte slices and forms all nine byte products with 8x8 stages. It then places the three products on the main diagonal side by side in one 48-bit word, pairs the off-diagonal products into wider words, and reduces everything with ripple adders of 16 and 8 bits. Every carry out is passed up to the next slice.

The block is used wherever a full-width unsigned product is needed in one combinational step, for example in the significand path of a single-precision floating-point multiplier.

Top module: `ut_mul24`

## Requirements
- R1: For any operands, `p` equals the unsigned product of `a` and `b`, all 48 bits kept and nothing truncated.
- R2: The 4x4 cell returns the exact 8-bit product for all 256 pairs of nibble operands.
- R3: The 8x8 stage returns the exact 16-bit product for all 65,536 pairs of byte operands.
- R4: If either operand is zero, `p` is zero.
- R5: If one operand is 1, `p` equals the other operand zero-extended to 48 bits.
- R6: When both operands are all ones, `p` is 0xFFFFFE000001.
- R7: For operands 2^i and 2^j, `p` has exactly one bit set, at position i+j, for all i and j from 0 to 23.
- R8: Operand pairs drawn from the alternating patterns 0xAAAAAA and 0x555555 give the exact product. These patterns drive carries across every slice boundary.
- R9: `p` is purely combinational. It follows a change of `a` or `b` within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 24 | Unsigned multiplicand |
| b | input | 24 | Unsigned multiplier |
| p | output | 48 | Unsigned product of `a` and `b` |

## Verification
Assertions check the arithmetic on every evaluation. They compare each adder's outputs with its operands, each 4x4 cell and 8x8 stage with its own product, and the top product with its operands. They also require that the final adder's carry out is zero, that the two top carries of the merge tree are never both set, and that a zero operand gives a zero product. Only the bench can show coverage. It sweeps the 4x4 cell and the 8x8 stage exhaustively, runs the named corner operands and a large set of random pairs through the top, and changes inputs between clock edges to show that the output follows without a register.

// File: rtl/ut_mul_pkg.sv
// Package: ut_mul_pkg
// Holds the widths shared by every level of the crosswise multiplier.
// Assumes the top is always three byte slices per operand; the merge
// tree in ut_mul24 is written for exactly that split.
package ut_mul_pkg;
    localparam int CELL_W   = 4;              // base cell operand width
    localparam int STAGE_W  = 2 * CELL_W;     // middle stage operand width
    localparam int SLICE_N  = 3;              // byte slices per top operand
    localparam int TOP_W    = STAGE_W * SLICE_N;
    localparam int PROD_W   = 2 * TOP_W;
    localparam int PP_W     = 2 * STAGE_W;    // width of one byte product

    typedef logic [STAGE_W-1:0] slice_t;
    typedef logic [PP_W-1:0]    slice_prod_t;
endpackage

// File: rtl/ut_fa.sv
// Module: ut_fa
// One-bit full adder described with gates: the sum is the XOR of the three
// inputs and the carry is their majority. With cin tied low it serves as
// a half adder. Assumes nothing beyond single-bit inputs.
module ut_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    // sum and majority carry
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
    end
endmodule

// File: rtl/ut_ripple.sv
// Module: ut_ripple
// W-bit ripple-carry adder built from a chain of ut_fa instances.
// Assumes W >= 1. The carry enters at bit 0 and leaves from bit W-1.
module ut_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] cc;

    assign cc[0] = ci;

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_bit
            ut_fa fa_i (
                .x  (x[k]),
                .y  (y[k]),
                .ci (cc[k]),
                .s  (s[k]),
                .co (cc[k+1])
            );
        end
    endgenerate

    assign co = cc[W];

    // the carry chain must reproduce the arithmetic sum of its operands
    always_comb begin
        p_ripple_sum_r1: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci}))
            else $error("ripple adder sum mismatch");
    end
endmodule

// File: rtl/ut_cell4.sv
// Module: ut_cell4
// 4x4 crosswise base cell. It forms the sixteen AND partial products and
// reduces them column by column. Each column adds its cross terms to the
// carries that come up from the column below. The low bit of that sum is
// the result bit and the rest moves up. Column 0 receives no carry.
// Half adders are ut_fa instances with cin tied low.
module ut_cell4
    import ut_mul_pkg::*;
(
    input  logic [CELL_W-1:0]   x,
    input  logic [CELL_W-1:0]   y,
    output logic [2*CELL_W-1:0] s
);
    logic [CELL_W-1:0][CELL_W-1:0] pp;   // pp[i][j] carries weight i+j

    genvar i, j;
    generate
        for (i = 0; i < CELL_W; i++) begin : g_row
            for (j = 0; j < CELL_W; j++) begin : g_col
                assign pp[i][j] = x[i] & y[j];
            end
        end
    endgenerate

    // column 0: a single term and no incoming carry
    assign s[0] = pp[0][0];

    // column 1: two terms
    logic c1;
    ut_fa h1 (.x(pp[1][0]), .y(pp[0][1]), .ci(1'b0), .s(s[1]), .co(c1));

    // column 2: three terms plus one carry
    logic x2, y2, z2;
    ut_fa f2a (.x(pp[2][0]), .y(pp[1][1]), .ci(pp[0][2]), .s(x2), .co(y2));
    ut_fa h2  (.x(x2), .y(c1), .ci(1'b0), .s(s[2]), .co(z2));

    // column 3: four terms plus two carries
    logic x3, y3, u3, v3, w3;
    ut_fa f3a (.x(pp[3][0]), .y(pp[2][1]), .ci(pp[1][2]), .s(x3), .co(y3));
    ut_fa f3b (.x(pp[0][3]), .y(y2), .ci(z2), .s(u3), .co(v3));
    ut_fa h3  (.x(x3), .y(u3), .ci(1'b0), .s(s[3]), .co(w3));

    // column 4: three terms plus three carries
    logic x4, y4, u4, v4, w4;
    ut_fa f4a (.x(pp[3][1]), .y(pp[2][2]), .ci(pp[1][3]), .s(x4), .co(y4));
    ut_fa f4b (.x(y3), .y(v3), .ci(w3), .s(u4), .co(v4));
    ut_fa h4  (.x(x4), .y(u4), .ci(1'b0), .s(s[4]), .co(w4));

    // column 5: two terms plus three carries
    logic x5, y5, v5;
    ut_fa f5a (.x(pp[3][2]), .y(pp[2][3]), .ci(y4), .s(x5), .co(y5));
    ut_fa f5b (.x(v4), .y(w4), .ci(x5), .s(s[5]), .co(v5));

    // column 6: one term plus two carries; its carry is the top bit
    ut_fa f6 (.x(pp[3][3]), .y(y5), .ci(v5), .s(s[6]), .co(s[7]));

    // the column reduction must equal the nibble product
    always_comb begin
        p_cell4_product_r2: assert (s == ({4'b0, x} * {4'b0, y}))
            else $error("4x4 cell product mismatch");
    end
endmodule

// File: rtl/ut_stage8.sv
// Module: ut_stage8
// 8x8 stage. Both operands are split into high and low nibbles and the
// four nibble products come from ut_cell4. Three 8-bit ripple adders
// merge them. The first adder cannot carry out because a nibble product
// plus a nibble stays below 256. The middle adder's carry feeds bit 12 of
// the product through the last adder.
module ut_stage8
    import ut_mul_pkg::*;
(
    input  logic [STAGE_W-1:0]   x,
    input  logic [STAGE_W-1:0]   y,
    output logic [2*STAGE_W-1:0] s
);
    localparam int H = CELL_W;

    logic [2*H-1:0] q_ll, q_hl, q_lh, q_hh;
    logic [2*H-1:0] t_sum, u_sum;
    logic           t_co, u_co, z_co;

    ut_cell4 c_ll (.x(x[H-1:0]),   .y(y[H-1:0]),   .s(q_ll));
    ut_cell4 c_hl (.x(x[2*H-1:H]), .y(y[H-1:0]),   .s(q_hl));
    ut_cell4 c_lh (.x(x[H-1:0]),   .y(y[2*H-1:H]), .s(q_lh));
    ut_cell4 c_hh (.x(x[2*H-1:H]), .y(y[2*H-1:H]), .s(q_hh));

    // cross term plus upper half of the low product, both at weight 4
    ut_ripple #(.W(2*H)) add_t (
        .x(q_hl), .y({{H{1'b0}}, q_ll[2*H-1:H]}), .ci(1'b0), .s(t_sum), .co(t_co));

    // second cross term joins at weight 4
    ut_ripple #(.W(2*H)) add_u (
        .x(t_sum), .y(q_lh), .ci(1'b0), .s(u_sum), .co(u_co));

    // high product plus what remains at weight 8, carry at bit 12
    ut_ripple #(.W(2*H)) add_z (
        .x(q_hh), .y({{(H-1){1'b0}}, u_co, u_sum[2*H-1:H]}), .ci(1'b0),
        .s(s[4*H-1:2*H]), .co(z_co));

    assign s[H-1:0]   = q_ll[H-1:0];
    assign s[2*H-1:H] = u_sum[H-1:0];

    // the stage output and its dropped carries
    always_comb begin
        p_stage8_product_r3: assert (s == ({8'b0, x} * {8'b0, y}))
            else $error("8x8 stage product mismatch");
        p_stage8_nolost_r3: assert (!t_co && !z_co)
            else $error("8x8 stage dropped a carry");
    end
endmodule

// File: rtl/ut_mul24.sv
// Module: ut_mul24
// 24x24 unsigned crosswise multiplier, purely combinational.
// Assumes three byte slices per operand. Nine ut_stage8 instances form
// pr[i][j] = a_i * b_j, which carries weight 8*(i+j). The three products
// on the main diagonal do not overlap, so they are placed side by side in
// one 48-bit word at no cost. The off-diagonal pairs (i,j) and (j,i) each
// sit in a 32-bit word at weight 8, and the pair at weight 16 is added
// first. Every carry out goes up to the next slice.
module ut_mul24
    import ut_mul_pkg::*;
(
    input  logic [TOP_W-1:0]  a,
    input  logic [TOP_W-1:0]  b,
    output logic [PROD_W-1:0] p
);
    localparam int SW = STAGE_W;    // 8
    localparam int DW = PP_W;       // 16

    slice_prod_t [SLICE_N-1:0][SLICE_N-1:0] pr;

    genvar i, j;
    generate
        for (i = 0; i < SLICE_N; i++) begin : g_ai
            for (j = 0; j < SLICE_N; j++) begin : g_bj
                ut_stage8 st_i (
                    .x (a[i*SW +: SW]),
                    .y (b[j*SW +: SW]),
                    .s (pr[i][j])
                );
            end
        end
    endgenerate

    logic [PROD_W-1:0] diag;       // main diagonal side by side, weight 0
    logic [2*DW-1:0]   up_w;       // {pr[1][2], pr[0][1]} at weight 8
    logic [2*DW-1:0]   dn_w;       // {pr[2][1], pr[1][0]} at weight 8

    assign diag = {pr[2][2], pr[1][1], pr[0][0]};
    assign up_w = {pr[1][2], pr[0][1]};
    assign dn_w = {pr[2][1], pr[1][0]};

    // weight-16 pair: pr[0][2] + pr[2][0]
    logic [DW-1:0] zs;
    logic          zc;
    ut_ripple #(.W(DW)) add_z (
        .x(pr[0][2]), .y(pr[2][0]), .ci(1'b0), .s(zs), .co(zc));

    // off-diagonal words, low then high half, at weight 8
    logic [2*DW-1:0] ws;
    logic            wc0, wc1;
    ut_ripple #(.W(DW)) add_wl (
        .x(up_w[DW-1:0]), .y(dn_w[DW-1:0]), .ci(1'b0), .s(ws[DW-1:0]), .co(wc0));
    ut_ripple #(.W(DW)) add_wh (
        .x(up_w[2*DW-1:DW]), .y(dn_w[2*DW-1:DW]), .ci(wc0),
        .s(ws[2*DW-1:DW]), .co(wc1));

    // fold the weight-16 pair into the off-diagonal sum (relative bit 8)
    logic [2*DW+1:0] vs;           // 34-bit sum, relative to weight 8
    logic            vc, ec;
    assign vs[SW-1:0] = ws[SW-1:0];
    ut_ripple #(.W(DW)) add_v (
        .x(ws[SW+DW-1:SW]), .y(zs), .ci(1'b0), .s(vs[SW+DW-1:SW]), .co(vc));
    ut_ripple #(.W(SW)) add_e (
        .x(ws[2*DW-1:SW+DW]), .y({{(SW-1){1'b0}}, zc}), .ci(vc),
        .s(vs[2*DW-1:SW+DW]), .co(ec));
    ut_fa ha_top (.x(wc1), .y(ec), .ci(1'b0), .s(vs[2*DW]), .co(vs[2*DW+1]));

    // final merge with the diagonal word: two 16-bit spans and an 8-bit top
    logic fc, gc, hc;
    assign p[SW-1:0] = diag[SW-1:0];
    ut_ripple #(.W(DW)) add_f (
        .x(diag[SW+DW-1:SW]), .y(vs[DW-1:0]), .ci(1'b0),
        .s(p[SW+DW-1:SW]), .co(fc));
    ut_ripple #(.W(DW)) add_g (
        .x(diag[SW+2*DW-1:SW+DW]), .y(vs[2*DW-1:DW]), .ci(fc),
        .s(p[SW+2*DW-1:SW+DW]), .co(gc));
    ut_ripple #(.W(SW)) add_h (
        .x(diag[PROD_W-1:SW+2*DW]), .y({{(SW-2){1'b0}}, vs[2*DW+1:2*DW]}), .ci(gc),
        .s(p[PROD_W-1:SW+2*DW]), .co(hc));

    // product, lost-carry and zero-operand checks on the merge tree
    always_comb begin
        p_top_product_r1: assert (p == ({24'b0, a} * {24'b0, b}))
            else $error("top product mismatch");
        p_no_lost_carry_r1: assert (!hc)
            else $error("final adder carried out of 48 bits");
        p_upper_carry_single_r1: assert (!(wc1 && ec))
            else $error("two carries reached bit 40 of the merge tree");
        p_zero_operand_r4: assert (!((a == '0) || (b == '0)) || (p == '0))
            else $error("zero operand gave a nonzero product");
    end
endmodule

// File: tb/ut_mul24_tb_top.sv
// Bench: ut_mul24_tb_top
// Directed scenarios, one task each, every task checking its own results.
// Inputs change half a cycle after a rising edge and outputs are sampled
// 1 ns later, away from any clock edge.
module ut_mul24_tb_top;
    logic        clk = 1'b0;
    logic [23:0] a, b;
    logic [47:0] p;
    logic [3:0]  n4x, n4y;
    logic [7:0]  c4p;
    logic [7:0]  n8x, n8y;
    logic [15:0] c8p;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;   // 100 MHz

    ut_mul24  dut_i (.a(a), .b(b), .p(p));
    ut_cell4  cell_i (.x(n4x), .y(n4y), .s(c4p));
    ut_stage8 stage_i (.x(n8x), .y(n8y), .s(c8p));

    // compare one value and report a mismatch
    task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive the top and check it against a bench-side product
    task automatic top_vec(input string req, input logic [23:0] x, input logic [23:0] y);
        @(negedge clk);
        a = x; b = y;
        #1;
        check(req, p, 48'(x) * 48'(y));
    endtask

    // R2: every nibble pair through the base cell
    task automatic t_cell4_sweep();
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                n4x = 4'(i); n4y = 4'(j);
                #1;
                check("R2", {40'b0, c4p}, 48'(i * j));
            end
        end
    endtask

    // R3: every byte pair through the middle stage
    task automatic t_stage8_sweep();
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                @(negedge clk);
                n8x = 8'(i); n8y = 8'(j);
                #1;
                check("R3", {32'b0, c8p}, 48'(i * j));
            end
        end
    endtask

    // R4: zero on either side and on both
    task automatic t_zero();
        top_vec("R4", 24'h0, 24'h0);
        top_vec("R4", 24'h0, 24'hFFFFFF);
        top_vec("R4", 24'hABCDEF, 24'h0);
        check("R4", p, 48'h0);
    endtask

    // R5: multiplying by one returns the other operand
    task automatic t_identity();
        top_vec("R5", 24'h1, 24'hC0FFEE);
        check("R5", p, 48'h000000C0FFEE);
        top_vec("R5", 24'hFFFFFF, 24'h1);
        check("R5", p, 48'h000000FFFFFF);
    endtask

    // R6: all ones on both operands
    task automatic t_all_ones();
        top_vec("R6", 24'hFFFFFF, 24'hFFFFFF);
        check("R6", p, 48'hFFFFFE000001);
    endtask

    // R7: every pair of single high bits lands on bit i+j
    task automatic t_powers();
        for (int i = 0; i < 24; i++) begin
            for (int j = 0; j < 24; j++) begin
                @(negedge clk);
                a = 24'(1) << i; b = 24'(1) << j;
                #1;
                check("R7", p, 48'(1) << (i + j));
            end
        end
    endtask

    // R8: alternating patterns that ripple carries through every slice
    task automatic t_alternating();
        top_vec("R8", 24'hAAAAAA, 24'h555555);
        top_vec("R8", 24'hAAAAAA, 24'hAAAAAA);
        top_vec("R8", 24'h555555, 24'h555555);
        top_vec("R8", 24'hFF00FF, 24'h00FF00);
        top_vec("R8", 24'h800001, 24'hFFFFFF);
    endtask

    // R9: inputs change twice between clock edges and p follows each time
    task automatic t_comb_update();
        @(negedge clk);
        a = 24'h000100; b = 24'h000200;
        #1;
        check("R9", p, 48'h000000020000);
        a = 24'h123456;
        #1;
        check("R9", p, 48'(24'h123456) * 48'(24'h000200));
        b = 24'hFEDCBA;
        #1;
        check("R9", p, 48'(24'h123456) * 48'(24'hFEDCBA));
    endtask

    // R1: random operand pairs against the bench product
    task automatic t_random();
        for (int n = 0; n < 10000; n++) begin
            top_vec("R1", 24'($urandom), 24'($urandom));
        end
    endtask

    // watchdog: a hung run is a failure and still prints the summary
    initial begin
        #(10 * 190000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // scenario sequence
    initial begin
        a = '0; b = '0; n4x = '0; n4y = '0; n8x = '0; n8y = '0;
        #1;
        check("R4", p, 48'h0);     // idle output with zero operands
        t_zero();
        t_identity();
        t_all_ones();
        t_powers();
        t_alternating();
        t_comb_update();
        t_cell4_sweep();
        t_stage8_sweep();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule